// File: doc/BRIEF.md
# Dual-Level Over-Current Detector

This block sets up and enforces over-current protection for a synchronous buck stage. Current is sensed as the voltage drop across the low-side switch while that switch conducts. After the supply comes out of undervoltage lockout, a fixed setting window opens. During the window the block watches a digitized pin-voltage code and keeps the last value as the first-level trip threshold. The window ends at once, with the threshold forced to its maximum, if the pin reaches the clamp level.

Once the threshold is set, the block compares the digitized switch-node drop against two limits:
- the programmed threshold;
- a derived limit of 1.5 times the threshold.

Comparisons are made only while the low-side switch is on. Crossing the derived limit trips protection immediately. Crossing the programmed threshold trips protection only after it happens in a run of consecutive switching cycles. A trip raises a latched fault that turns both power switches off. Only a drop of the supply-good input, which stands for a supply cycle, clears the fault. A controller instantiates the block, feeds it codes from its converters and uses the fault as a gate-kill.

Top module: `ocp_dual_level`

## Requirements
- R1: While `rst_n` is low or `uvlo_ok` is low on a clock edge, that edge clears `oc_set_done`, `oc_thresh` and `oc_fault` to 0. A low `uvlo_ok` is the only way to clear a latched fault.
- R2: After `uvlo_ok` rises, `oc_set_done` rises on the SET_CYCLES-th clock edge that samples `uvlo_ok` high. On that edge `oc_thresh` takes `pin_code` as sampled at that edge, limited to MAX_TH.
- R3: `oc_thresh` never exceeds MAX_TH.
- R4: If `pin_code` >= CLAMP_LVL on any edge inside the window, that edge ends the window: `oc_set_done` becomes 1 and `oc_thresh` becomes MAX_TH.
- R5: After setting, an edge that samples `ls_on` = 1 and `drop_code` > `oc_thresh` + floor(`oc_thresh`/2) sets `oc_fault`. The sum is evaluated one bit wider than the code, so it cannot overflow.
- R6: A switching cycle counts as a first-level event if `drop_code` > `oc_thresh` was seen with `ls_on` = 1 on any edge of that cycle, up to and including the edge where `cyc_strobe` = 1 closes the cycle. The edge that closes the CONSEC-th consecutive event cycle sets `oc_fault`. CONSEC defaults to 4.
- R7: A switching cycle closed without a first-level event resets the consecutive count to zero.
- R8: The value of `drop_code` has no effect on any edge where `ls_on` = 0.
- R9: `oc_fault` stays 1 until R1 clears it. No drop value can raise it before `oc_set_done` is 1.
- R10: `oc_thresh` does not change between the rise of `oc_set_done` and the next clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| uvlo_ok | input | 1 | Supply above lockout level; low acts as a supply cycle |
| pin_code | input | W | Digitized threshold-pin voltage |
| drop_code | input | W | Digitized switch-node drop across the low-side switch |
| ls_on | input | 1 | Low-side switch conducting |
| cyc_strobe | input | 1 | Marks the last clock of a switching cycle |
| oc_set_done | output | 1 | Threshold setting window has ended |
| oc_thresh | output | W | Held first-level threshold code |
| oc_fault | output | 1 | Latched over-current fault, both switches off |

## Verification
A wrong window counter shows up at the ports as `oc_set_done` rising one or more edges too early or too late. A threshold captured on the wrong edge shows up as a value different from the code presented on the final window edge. Both are visible the same cycle the window closes. A wrong consecutive count, or a count that fails to clear, moves the first-level trip by whole switching cycles, so the fault rises a strobe early or late. A wrong 1.5x sum shifts the immediate trip point by one code, and the probe just below and just above that point catches it on the very next edge.

// File: rtl/ocp_dual_level.sv
module ocp_dual_level #(
  parameter int W          = 8,
  parameter int SET_CYCLES = 250000,
  parameter int MAX_TH     = 110,
  parameter int CLAMP_LVL  = 120,
  parameter int CONSEC     = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         uvlo_ok,
  input  logic [W-1:0] pin_code,
  input  logic [W-1:0] drop_code,
  input  logic         ls_on,
  input  logic         cyc_strobe,
  output logic         oc_set_done,
  output logic [W-1:0] oc_thresh,
  output logic         oc_fault
);
  localparam int CW = $clog2(SET_CYCLES + 1);
  localparam int KW = $clog2(CONSEC + 1);
  localparam logic [W-1:0] MAX_C = W'(MAX_TH);

  logic [CW-1:0] win_cnt;
  logic [KW-1:0] run_cnt;
  logic          seen;

  wire [W:0]     lim2     = {1'b0, oc_thresh} + {2'b00, oc_thresh[W-1:1]};
  wire           hit1     = ls_on && (drop_code > oc_thresh);
  wire           hit2     = ls_on && ({1'b0, drop_code} > lim2);
  wire           win_last = (win_cnt == CW'(SET_CYCLES - 1));
  wire           pin_big  = (pin_code >= W'(CLAMP_LVL));
  wire [W-1:0]   pin_lim  = (pin_code > MAX_C) ? MAX_C : pin_code;
  wire           event1   = seen || hit1;

  always_ff @(posedge clk) begin
    if (!rst_n || !uvlo_ok) begin
      win_cnt     <= '0;
      run_cnt     <= '0;
      seen        <= 1'b0;
      oc_set_done <= 1'b0;
      oc_thresh   <= '0;
      oc_fault    <= 1'b0;
    end else if (!oc_set_done) begin
      if (pin_big) begin
        oc_thresh   <= MAX_C;
        oc_set_done <= 1'b1;
      end else if (win_last) begin
        oc_thresh   <= pin_lim;
        oc_set_done <= 1'b1;
      end else begin
        win_cnt <= win_cnt + 1'b1;
      end
    end else if (!oc_fault) begin
      if (hit2) oc_fault <= 1'b1;
      if (cyc_strobe) begin
        seen <= 1'b0;
        if (event1) begin
          if (run_cnt == KW'(CONSEC - 1)) oc_fault <= 1'b1;
          else run_cnt <= run_cnt + 1'b1;
        end else begin
          run_cnt <= '0;
        end
      end else if (hit1) begin
        seen <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ocp_dual_level_chk.sv
module ocp_dual_level_chk #(
  parameter int W      = 8,
  parameter int MAX_TH = 110
) (
  input logic         clk,
  input logic         rst_n,
  input logic         uvlo_ok,
  input logic [W-1:0] drop_code,
  input logic         ls_on,
  input logic         oc_set_done,
  input logic [W-1:0] oc_thresh,
  input logic         oc_fault
);
  logic [W:0] lim2;
  assign lim2 = {1'b0, oc_thresh} + {2'b00, oc_thresh[W-1:1]};

  AST_SUPPLY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !uvlo_ok |=> (!oc_fault && !oc_set_done && oc_thresh == '0)); // R1
  AST_THRESH_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    oc_thresh <= W'(MAX_TH)); // R3
  AST_FAST_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (uvlo_ok && oc_set_done && ls_on && {1'b0, drop_code} > lim2) |=> oc_fault); // R5
  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_fault && uvlo_ok) |=> oc_fault); // R9
  AST_NO_EARLY_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !oc_set_done |-> !oc_fault); // R9
  AST_THRESH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_set_done && uvlo_ok) |=> $stable(oc_thresh)); // R10
endmodule

bind ocp_dual_level ocp_dual_level_chk #(.W(W), .MAX_TH(MAX_TH)) u_chk (
  .clk(clk), .rst_n(rst_n), .uvlo_ok(uvlo_ok), .drop_code(drop_code),
  .ls_on(ls_on), .oc_set_done(oc_set_done), .oc_thresh(oc_thresh),
  .oc_fault(oc_fault)
);

// File: tb/sim_ocp_dual_level.sv
module sim_ocp_dual_level;
  localparam int W = 8, SETC = 8, MAXT = 110, CLMP = 120, CONS = 4;

  logic clk = 0, rst_n = 0, uvlo_ok = 0, ls_on = 0, cyc_strobe = 0;
  logic [W-1:0] pin_code = 0, drop_code = 0;
  logic oc_set_done, oc_fault;
  logic [W-1:0] oc_thresh;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  ocp_dual_level #(.W(W), .SET_CYCLES(SETC), .MAX_TH(MAXT), .CLAMP_LVL(CLMP), .CONSEC(CONS)) u0 (
    .clk(clk), .rst_n(rst_n), .uvlo_ok(uvlo_ok), .pin_code(pin_code),
    .drop_code(drop_code), .ls_on(ls_on), .cyc_strobe(cyc_strobe),
    .oc_set_done(oc_set_done), .oc_thresh(oc_thresh), .oc_fault(oc_fault));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit ls, input int d, input bit s);
    ls_on = ls; drop_code = W'(d); cyc_strobe = s;
    @(negedge clk);
  endtask

  task automatic pwr(input int p);
    int n;
    uvlo_ok = 0; ls_on = 1; drop_code = '1; cyc_strobe = 0;
    @(negedge clk);
    chk("R1 done cleared", oc_set_done, 0);
    chk("R1 thresh cleared", oc_thresh, 0);
    chk("R1 fault cleared", oc_fault, 0);
    uvlo_ok = 1;
    pin_code = (p >= CLMP) ? W'(p) : W'((p + 37) % CLMP);
    n = 0;
    if (SETC == 1) pin_code = W'(p);
    while (!oc_set_done && n < 20) begin
      @(negedge clk);
      n++;
      if (n == SETC - 1) pin_code = W'(p);
    end
    ls_on = 0; drop_code = 0;
    if (p >= CLMP) chk("R4 early end edges", n, 1);
    else chk("R2 window edges", n, SETC);
    chk(p >= CLMP ? "R4 clamp value" : "R2 R3 captured threshold", oc_thresh, (p > MAXT) ? MAXT : p);
    @(negedge clk);
    chk("R9 no fault during window", oc_fault, 0);
  endtask

  task automatic report;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    int ths[8] = '{2, 3, 7, 50, 77, 100, 109, 110};
    repeat (3) @(negedge clk);
    chk("R1 reset done", oc_set_done, 0);
    chk("R1 reset fault", oc_fault, 0);
    rst_n = 1;
    @(negedge clk);

    for (int p = 0; p < 256; p++) pwr(p);

    for (int p = 0; p < 2; p++) begin
      pwr(p);
      cyc(1, p + p / 2 + 1, 0);
      chk("R5 fast trip small threshold", oc_fault, 1);
    end

    foreach (ths[i]) begin
      int t, t2;
      t = ths[i]; t2 = t + t / 2;
      pwr(t);
      cyc(0, 255, 1);
      cyc(0, 255, 0);
      chk("R8 drop ignored with low side off", oc_fault, 0);
      cyc(1, t2, 0);
      chk("R5 at derived limit no trip", oc_fault, 0);
      cyc(1, t2 + 1, 0);
      chk("R5 above derived limit trips", oc_fault, 1);
      repeat (4) cyc(0, 0, 1);
      chk("R9 fault held", oc_fault, 1);
      chk("R10 threshold held", oc_thresh, t);

      pwr(t);
      for (int k = 1; k <= CONS; k++) begin
        cyc(1, t + 1, 0);
        cyc(0, 0, 1);
        chk("R6 consecutive events", oc_fault, (k == CONS) ? 1 : 0);
      end

      pwr(t);
      for (int k = 0; k < CONS - 1; k++) cyc(1, t + 1, 1);
      cyc(1, t, 1);
      chk("R7 quiet cycle no trip", oc_fault, 0);
      for (int k = 1; k <= CONS; k++) begin
        cyc(1, t + 1, 1);
        chk("R7 count restarted", oc_fault, (k == CONS) ? 1 : 0);
      end
      uvlo_ok = 0;
      cyc(0, 0, 0);
      chk("R1 supply cycle clears fault", oc_fault, 0);
    end

    report();
  end
endmodule